// File: doc/BRIEF.md
# Multi-Lane Ring Waveform Player

This block plays one stored waveform segment out of an on-chip sample memory, over and over, and presents several consecutive samples per clock on a wide bus. The bus feeds a converter interface that serializes the lanes at a higher rate. Each memory word holds four samples. Every sample carries two marker bits stored next to it. The markers leave the block in the same cycle and the same lane as their sample, so sync outputs derived from them stay aligned with the waveform.

A segment is chosen by a word-aligned start pointer into the shared memory and a length counted in samples. The engine reads only whole words, so the length is rounded down to a multiple of the lane count. A length that rounds down to zero words is refused: the block raises an error flag and produces no output. A level-sensitive run input starts and stops playback. A one-cycle wrap pulse marks the last word of every pass. The start pointer and the length are taken only when playback starts and at each wrap, so a pass is never altered midway. The memory is loaded through a simple synchronous write port.

Top module: `wave_ring_player`

## Requirements
- R1: While playing, the words read follow the addresses start, start+1, ..., start+W-1 and then start again, where W is floor(length/4). Addresses are modulo 64.
- R2: Stored word bits [18i+15:18i] are the sample of lane i and bits [18i+17:18i+16] are its markers. They appear on out_samples[16i+15:16i] and out_markers[2i+1:2i] in the same cycle. Lane 0 is the earliest sample.
- R3: A length L gives passes of exactly floor(L/4) words. The low two bits of L are ignored.
- R4: If run is first sampled high at clock edge k from idle, with a valid length, then out_valid rises after edge k+1 carrying the word at the start address.
- R5: Changes to start and length made during a pass have no effect until the next wrap.
- R6: out_wrap is high for exactly the cycle that carries the last word of a pass, and only with out_valid.
- R7: If a length below 4 is taken at start, len_err is high from the next edge and no word is output. If such a length is taken at a wrap, the last word of that pass is still output, then output stops and len_err is raised. len_err clears at the first edge at which run is low.
- R8: From the first edge at which run is sampled low, out_valid is 0 and out_samples and out_markers are all zero. The next start begins again at the start address.
- R9: A word written with wr_en at wr_addr is returned by later reads of that address.
- R10: During and after reset, out_valid, out_wrap and len_err are 0 and the data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Memory write strobe |
| wr_addr | input | 6 | Memory word address for writes |
| wr_data | input | 72 | Word to store: four lanes of marker and sample |
| run | input | 1 | Play while high, stop while low |
| seg_start | input | 6 | Segment start word address |
| seg_len | input | 10 | Segment length in samples |
| out_valid | output | 1 | Output word is valid |
| out_samples | output | 64 | Four samples, lane 0 lowest |
| out_markers | output | 8 | Marker bits, two per lane |
| out_wrap | output | 1 | Last word of a pass |
| len_err | output | 1 | Refused length |

## Verification
A wrong address counter or a wrong word count shows up on the data bus within one pass. The wrong words appear in the cycle after the bad read, and the wrap pulse lands on the wrong cycle. A state machine that latches the length at the wrong time only shows its error at the next wrap, so the bench changes the length and the pointer midway through a pass and checks the words that follow. Lane or marker misrouting is visible in the first valid word, because every lane of the loaded pattern encodes its own address and lane index.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

    // Geometry of one memory word
    localparam int LANES    = 4;
    localparam int SAMPLE_W = 16;
    localparam int MARK_W   = 2;
    localparam int LANE_W   = SAMPLE_W + MARK_W;
    localparam int WORD_W   = LANES * LANE_W;

    // Memory and length sizing
    localparam int ADDR_W   = 6;
    localparam int LEN_W    = 10;
    localparam int LANE_SH  = $clog2(LANES);
    localparam int WCNT_W   = LEN_W - LANE_SH;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLAY  = 2'd1,
        ST_FAULT = 2'd2
    } play_st_e;

    // Control that travels alongside a read word
    typedef struct packed {
        logic valid;
        logic last;
    } beat_t;

    localparam beat_t BEAT_NONE = '{valid: 1'b0, last: 1'b0};

endpackage

// File: rtl/wrp_word_ram.sv
module wrp_word_ram
    import wrp_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int D_W = WORD_W
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [A_W-1:0] wr_addr,
    input  logic [D_W-1:0] wr_data,
    input  logic [A_W-1:0] rd_addr,
    output logic [D_W-1:0] rd_data
);

    localparam int DEPTH = 1 << A_W;

    logic [D_W-1:0] store [DEPTH];

    // Registered read; a read in the same cycle as a write returns old data
    always_ff @(posedge clk) begin
        rd_data <= store[rd_addr];
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/wrp_seq_ctrl.sv
module wrp_seq_ctrl
    import wrp_pkg::*;
#(
    parameter int A_W     = ADDR_W,
    parameter int L_W     = LEN_W,
    parameter int N_LANES = LANES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [A_W-1:0] seg_start,
    input  logic [L_W-1:0] seg_len,
    output logic [A_W-1:0] rd_addr,
    output beat_t          beat,
    output logic           fault
);

    localparam int SH  = $clog2(N_LANES);
    localparam int C_W = L_W - SH;
    localparam logic [C_W-1:0] C_ONE  = C_W'(1);
    localparam logic [A_W-1:0] A_ONE  = A_W'(1);

    play_st_e       state_q;
    logic [A_W-1:0] addr_q;
    logic [C_W-1:0] cnt_q;
    logic [C_W-1:0] words_q;

    logic [C_W-1:0] words_new;
    logic           len_ok;
    logic           at_last;
    logic           issue;

    // Granularity: whole words only, the remainder is dropped
    assign words_new = C_W'(seg_len >> SH);
    assign len_ok    = (words_new != '0);
    assign at_last   = (cnt_q == words_q - C_ONE);
    assign issue     = (state_q == ST_PLAY) && run;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            cnt_q   <= '0;
            words_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (run) begin
                        if (len_ok) begin
                            state_q <= ST_PLAY;
                            addr_q  <= seg_start;
                            cnt_q   <= '0;
                            words_q <= words_new;
                        end else begin
                            state_q <= ST_FAULT;
                        end
                    end
                end
                ST_PLAY: begin
                    if (!run) begin
                        state_q <= ST_IDLE;
                    end else if (at_last) begin
                        if (len_ok) begin
                            addr_q  <= seg_start;
                            cnt_q   <= '0;
                            words_q <= words_new;
                        end else begin
                            state_q <= ST_FAULT;
                        end
                    end else begin
                        addr_q <= addr_q + A_ONE;
                        cnt_q  <= cnt_q + C_ONE;
                    end
                end
                ST_FAULT: begin
                    if (!run) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_addr    = addr_q;
    assign beat.valid = issue;
    assign beat.last  = issue && at_last;
    assign fault      = (state_q == ST_FAULT);

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PLAY && $past(state_q == ST_PLAY) && !$past(at_last))
            |-> (addr_q == $past(addr_q) + A_ONE)); // R1

    AST_RING_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PLAY && $past(state_q == ST_PLAY) && $past(at_last))
            |-> (addr_q == $past(seg_start) && cnt_q == '0)); // R1

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PLAY && $past(state_q == ST_PLAY) && !$past(at_last))
            |-> $stable(words_q)); // R5

    AST_NO_EMPTY_PASS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PLAY) |-> (words_q != '0 && cnt_q < words_q)); // R3

endmodule

// File: rtl/wrp_out_stage.sv
module wrp_out_stage
    import wrp_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int S_W     = SAMPLE_W,
    parameter int M_W     = MARK_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  beat_t                    beat_in,
    input  logic [N_LANES*(S_W+M_W)-1:0] word,
    output logic                     out_valid,
    output logic [N_LANES*S_W-1:0]   out_samples,
    output logic [N_LANES*M_W-1:0]   out_markers,
    output logic                     out_wrap
);

    localparam int L_W = S_W + M_W;

    beat_t beat_q;

    // Aligns the control with the registered memory read
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= BEAT_NONE;
        end else begin
            beat_q <= beat_in;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_LANES; g++) begin : g_lane
            logic [S_W-1:0] smp;
            logic [M_W-1:0] mrk;
            assign smp = word[g*L_W +: S_W];
            assign mrk = word[g*L_W + S_W +: M_W];
            assign out_samples[g*S_W +: S_W] = beat_q.valid ? smp : '0;
            assign out_markers[g*M_W +: M_W] = beat_q.valid ? mrk : '0;
        end
    endgenerate

    assign out_valid = beat_q.valid;
    assign out_wrap  = beat_q.last;

    AST_WRAP_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        out_wrap |-> out_valid); // R6

endmodule

// File: rtl/wave_ring_player.sv
module wave_ring_player
    import wrp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     run,
    input  logic [ADDR_W-1:0]        seg_start,
    input  logic [LEN_W-1:0]         seg_len,
    output logic                     out_valid,
    output logic [LANES*SAMPLE_W-1:0] out_samples,
    output logic [LANES*MARK_W-1:0]  out_markers,
    output logic                     out_wrap,
    output logic                     len_err
);

    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    beat_t             beat;

    wrp_seq_ctrl #(
        .A_W    (ADDR_W),
        .L_W    (LEN_W),
        .N_LANES(LANES)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .seg_start(seg_start),
        .seg_len  (seg_len),
        .rd_addr  (rd_addr),
        .beat     (beat),
        .fault    (len_err)
    );

    wrp_word_ram #(
        .A_W(ADDR_W),
        .D_W(WORD_W)
    ) u_ram (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_word)
    );

    wrp_out_stage #(
        .N_LANES(LANES),
        .S_W    (SAMPLE_W),
        .M_W    (MARK_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .beat_in    (beat),
        .word       (rd_word),
        .out_valid  (out_valid),
        .out_samples(out_samples),
        .out_markers(out_markers),
        .out_wrap   (out_wrap)
    );

    AST_STOP_BLANKS: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!out_valid && out_samples == '0 && out_markers == '0)); // R8

    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (len_err && $past(len_err)) |-> !out_valid); // R7

endmodule

// File: tb/wave_ring_player_bench.sv
module wave_ring_player_bench;
    import wrp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1 << ADDR_W;

    logic                      clk = 1'b0;
    logic                      rst;
    logic                      wr_en;
    logic [ADDR_W-1:0]         wr_addr;
    logic [WORD_W-1:0]         wr_data;
    logic                      run;
    logic [ADDR_W-1:0]         seg_start;
    logic [LEN_W-1:0]          seg_len;
    logic                      out_valid;
    logic [LANES*SAMPLE_W-1:0] out_samples;
    logic [LANES*MARK_W-1:0]   out_markers;
    logic                      out_wrap;
    logic                      len_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_ring_player u_wave_ring_player (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run(run), .seg_start(seg_start),
        .seg_len(seg_len), .out_valid(out_valid), .out_samples(out_samples),
        .out_markers(out_markers), .out_wrap(out_wrap), .len_err(len_err)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [WORD_W-1:0] pat(input int a);
        logic [WORD_W-1:0] w = '0;
        for (int i = 0; i < LANES; i++) begin
            w[i*LANE_W +: SAMPLE_W]          = 16'h8000 | 16'(a << 4) | 16'(i);
            w[i*LANE_W + SAMPLE_W +: MARK_W] = 2'(a + i);
        end
        return w;
    endfunction

    function automatic logic [LANES*SAMPLE_W-1:0] smp_of(input logic [WORD_W-1:0] w);
        logic [LANES*SAMPLE_W-1:0] s;
        for (int i = 0; i < LANES; i++) s[i*SAMPLE_W +: SAMPLE_W] = w[i*LANE_W +: SAMPLE_W];
        return s;
    endfunction

    function automatic logic [LANES*MARK_W-1:0] mrk_of(input logic [WORD_W-1:0] w);
        logic [LANES*MARK_W-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*MARK_W +: MARK_W] = w[i*LANE_W + SAMPLE_W +: MARK_W];
        return m;
    endfunction

    // Behavioural reference model
    logic [WORD_W-1:0] mdl_mem [DEPTH];
    bit m_active = 0, m_err = 0;
    int m_addr = 0, m_cnt = 0, m_words = 0;
    logic e_valid = 0, e_wrap = 0;
    logic [WORD_W-1:0] e_word = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0; m_err = 0;
            e_valid = 0; e_wrap = 0; e_word = '0;
        end else begin
            if (m_active && run) begin
                e_valid = 1; e_word = mdl_mem[m_addr]; e_wrap = (m_cnt == m_words - 1);
            end else begin
                e_valid = 0; e_word = '0; e_wrap = 0;
            end
            if (!run) begin
                m_active = 0; m_err = 0;
            end else if (m_err) begin
                m_err = 1;
            end else if (!m_active || m_cnt == m_words - 1) begin
                if (int'(seg_len) / LANES == 0) begin
                    m_err = 1; m_active = 0;
                end else begin
                    m_active = 1; m_words = int'(seg_len) / LANES;
                    m_addr = int'(seg_start); m_cnt = 0;
                end
            end else begin
                m_addr = (m_addr + 1) % DEPTH; m_cnt++;
            end
        end
        if (wr_en) mdl_mem[wr_addr] = wr_data;
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(out_valid === e_valid, "R4 valid", WORD_W'(out_valid), WORD_W'(e_valid));
            chk(out_samples === smp_of(e_word), "R1 samples", WORD_W'(out_samples), WORD_W'(smp_of(e_word)));
            chk(out_markers === mrk_of(e_word), "R2 markers", WORD_W'(out_markers), WORD_W'(mrk_of(e_word)));
            chk(out_wrap === e_wrap, "R6 wrap", WORD_W'(out_wrap), WORD_W'(e_wrap));
            chk(len_err === m_err, "R7 len_err", WORD_W'(len_err), WORD_W'(m_err));
        end
    end

    task automatic start_seg(input int st, input int len);
        seg_start = ADDR_W'(st);
        seg_len   = LEN_W'(len);
        run       = 1'b1;
    endtask

    task automatic stop_play();
        run = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int wraps;
        rst = 1'b1; run = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        seg_start = '0; seg_len = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!out_valid && !out_wrap && !len_err && out_samples == '0 && out_markers == '0,
            "R10 reset", WORD_W'({out_valid, out_wrap, len_err}), '0);

        // R9 load memory
        for (int a = 0; a < DEPTH; a++) begin
            wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = pat(a);
            @(negedge clk);
        end
        wr_en = 1'b0;

        // R4 start latency
        start_seg(5, 16);
        @(negedge clk);
        chk(!out_valid, "R4 one edge", WORD_W'(out_valid), '0);
        @(negedge clk);
        chk(out_valid && out_samples == smp_of(pat(5)), "R4 first word",
            WORD_W'(out_samples), WORD_W'(smp_of(pat(5))));
        repeat (6) @(negedge clk);

        // R8 stop blanks the outputs
        run = 1'b0;
        @(negedge clk);
        chk(!out_valid && out_samples == '0 && out_markers == '0, "R8 stop",
            WORD_W'({out_samples, out_markers}), '0);
        @(negedge clk);

        // R3 truncation: length 10 gives 2 words per pass
        start_seg(20, 10);
        repeat (2) @(negedge clk);
        wraps = 0;
        for (int k = 0; k < 10; k++) begin
            if (out_wrap) wraps++;
            @(negedge clk);
        end
        chk(wraps == 5, "R3 pass length", WORD_W'(wraps), WORD_W'(5));
        stop_play();

        // R5 mid-pass change has no effect until wrap
        start_seg(0, 32);
        repeat (4) @(negedge clk);
        seg_start = ADDR_W'(40); seg_len = LEN_W'(8);
        @(negedge clk);
        chk(out_samples == smp_of(pat(3)), "R5 pass continues",
            WORD_W'(out_samples), WORD_W'(smp_of(pat(3))));
        for (int k = 0; k < 20 && !out_wrap; k++) @(negedge clk);
        @(negedge clk);
        chk(out_samples == smp_of(pat(40)), "R1 restart at new start",
            WORD_W'(out_samples), WORD_W'(smp_of(pat(40))));

        // R7 invalid length taken at wrap
        seg_len = LEN_W'(2);
        @(negedge clk);
        chk(out_valid && out_wrap && len_err && out_samples == smp_of(pat(41)),
            "R7 last word then fault", WORD_W'(out_samples), WORD_W'(smp_of(pat(41))));
        @(negedge clk);
        chk(!out_valid && len_err, "R7 silent in fault", WORD_W'({out_valid, len_err}), WORD_W'(1));
        run = 1'b0;
        @(negedge clk);
        chk(!len_err, "R7 clears on stop", WORD_W'(len_err), '0);

        // R7 invalid length at start
        start_seg(10, 3);
        @(negedge clk);
        chk(len_err && !out_valid, "R7 refused start", WORD_W'({out_valid, len_err}), WORD_W'(1));
        repeat (3) @(negedge clk);
        chk(!out_valid, "R7 no output", WORD_W'(out_valid), '0);
        stop_play();

        // R9 rewrite one word and play it, R2 markers follow
        wr_en = 1'b1; wr_addr = ADDR_W'(50); wr_data = ~pat(50);
        @(negedge clk);
        wr_en = 1'b0;
        start_seg(50, 4);
        repeat (2) @(negedge clk);
        chk(out_samples == smp_of(~pat(50)), "R9 rewritten samples",
            WORD_W'(out_samples), WORD_W'(smp_of(~pat(50))));
        chk(out_markers == mrk_of(~pat(50)), "R2 rewritten markers",
            WORD_W'(out_markers), WORD_W'(mrk_of(~pat(50))));
        stop_play();

        // R1 address wraps around the memory end
        start_seg(62, 16);
        repeat (12) @(negedge clk);
        stop_play();
        repeat (2) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL R4 watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule